// File: doc/BRIEF.md
# Two-Wire Controlled Stereo Crossbar

This block is a write-only two-wire (I2C) target that holds the routing state for a digital stereo crossbar. The crossbar has six stereo sources and three stereo destinations. Each destination carries either the left and right samples of one chosen source or silence, which is all-zero samples. A host changes the routing by writing one-byte commands. Each command names one destination and one source code.

SCL and SDA arrive as plain inputs. The block pulls SDA low through an output-enable, and the board supplies the open-drain wiring. Both lines pass through a two-flop synchroniser into the system clock, and only then are START, STOP and SCL edges detected. A strap pin picks one of two bus addresses, so two crossbars can share one bus. The block never stretches the clock and has no read path.

Top module: `stereo_route_matrix`

## Requirements
- R1: After reset, every destination outputs all-zero samples on both channels and `sdaOe` is low.
- R2: With `addrSel` low, the 8-bit write address 0x98 is acknowledged and 0x9A is not.
- R3: With `addrSel` high, the 8-bit write address 0x9A is acknowledged and 0x98 is not.
- R4: An address byte with the read bit (bit 0) set, or an address that does not match, gets no acknowledge. Every byte after it is ignored until the next START.
- R5: In a data byte, bits 6:5 pick the destination (00 = destination 1, 01 = destination 2, 10 = destination 3). Bits 2:0 pick the source, where codes 000 to 101 mean sources 1 to 6. For example, 0x44 routes source 5 to destination 3.
- R6: Bits 7, 4 and 3 of a data byte have no effect on routing.
- R7: Source codes 110 and 111 silence the chosen destination, which then outputs zero on both channels.
- R8: A data byte with destination code 11 is acknowledged and changes no destination.
- R9: Any number of data bytes may follow one matched address. Each byte takes effect once its eighth bit has been sampled, before the transaction ends.
- R10: Both channels of a destination switch on the same clock edge. Outputs are registered and follow the stored selection one cycle later.
- R11: The block pulls SDA low only during the ninth clock of an accepted byte. It starts and stops pulling only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen on the pin |
| sdaIn | input | 1 | Bus data line as seen on the pin |
| sdaOe | output | 1 | When high, the pad pulls SDA low |
| addrSel | input | 1 | Address strap: low selects 0x98, high selects 0x9A |
| srcLeft | input | 6x16 | Left samples of the six sources, source 1 at index 0 |
| srcRight | input | 6x16 | Right samples of the six sources |
| dstLeft | output | 3x16 | Left samples of the three destinations, destination 1 at index 0 |
| dstRight | output | 3x16 | Right samples of the three destinations |

## Verification
The assertions check on every cycle that both channels of each destination equal the source chosen by the stored selection one cycle earlier. They also check that a silenced destination outputs zeros, that a command for the reserved destination code leaves the selections untouched, and that the acknowledge drive only changes while SCL is low. Some behaviour can only be shown by the bench's bus scenarios: which address bytes win an acknowledge under each strap setting, that bytes after a refused address are dropped, that don't-care bits are ignored, and that each byte of a multi-byte write lands before STOP.

// File: rtl/route_pkg.sv
package route_pkg;
  localparam int OUT_IDX_W = 2;
  localparam int SRC_CODE_W = 3;
  localparam logic [SRC_CODE_W-1:0] SILENCE_CODE = 3'd6;

  typedef struct packed {
    logic                  load;
    logic [OUT_IDX_W-1:0]  outIdx;
    logic [SRC_CODE_W-1:0] srcCode;
  } route_cmd_t;

  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_ADDR,
    BUS_DATA,
    BUS_ACK
  } bus_state_e;
endpackage

// File: rtl/route_sync2.sv
module route_sync2 #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= RESET_VAL;
      q      <= RESET_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/route_bus_ctrl.sv
module route_bus_ctrl
  import route_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR_BASE = 7'h4C
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       addrSel,
  output logic       sdaOe,
  output route_cmd_t cmd
);
  localparam int LINE_CNT = 2;
  localparam int BIT_CNT_W = 4;
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = 4'd7;
  localparam logic [BIT_CNT_W-1:0] BYTE_FULL = 4'd8;

  logic [LINE_CNT-1:0] rawLines;
  logic [LINE_CNT-1:0] syncLines;
  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall, startSeen, stopSeen;
  logic [6:0] shiftReg;
  logic [7:0] nextByte;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic addrOk;
  logic [6:0] myAddr;
  bus_state_e state;

  assign rawLines = {sclIn, sdaIn};

  for (genvar g = 0; g < LINE_CNT; g++) begin : g_sync
    route_sync2 #(.RESET_VAL(1'b1)) sync_i (
      .clk (clk),
      .rstN(rstN),
      .d   (rawLines[g]),
      .q   (syncLines[g])
    );
  end

  assign sclS = syncLines[1];
  assign sdaS = syncLines[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign startSeen = sclS & sclD & sdaD & ~sdaS;
  assign stopSeen  = sclS & sclD & ~sdaD & sdaS;
  assign nextByte  = {shiftReg, sdaS};
  assign myAddr    = {DEV_ADDR_BASE[6:1], addrSel};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= BUS_IDLE;
      bitCnt   <= '0;
      shiftReg <= '0;
      addrOk   <= 1'b0;
      sdaOe    <= 1'b0;
      cmd      <= '0;
    end else begin
      cmd.load <= 1'b0;
      if (stopSeen) begin
        state <= BUS_IDLE;
        sdaOe <= 1'b0;
      end else if (startSeen) begin
        state  <= BUS_ADDR;
        bitCnt <= '0;
        addrOk <= 1'b0;
        sdaOe  <= 1'b0;
      end else begin
        case (state)
          BUS_ADDR, BUS_DATA: begin
            if (sclRise && bitCnt < BYTE_FULL) begin
              shiftReg <= nextByte[6:0];
              bitCnt   <= bitCnt + 4'd1;
              if (bitCnt == LAST_BIT) begin
                if (state == BUS_ADDR) begin
                  addrOk <= (nextByte == {myAddr, 1'b0});
                end else begin
                  cmd.load    <= 1'b1;
                  cmd.outIdx  <= nextByte[6:5];
                  cmd.srcCode <= nextByte[2:0];
                end
              end
            end else if (sclFall && bitCnt == BYTE_FULL) begin
              if (state == BUS_DATA || addrOk) begin
                state <= BUS_ACK;
                sdaOe <= 1'b1;
              end else begin
                state <= BUS_IDLE;
              end
            end
          end
          BUS_ACK: begin
            if (sclFall) begin
              sdaOe  <= 1'b0;
              state  <= BUS_DATA;
              bitCnt <= '0;
            end
          end
          default: begin
            sdaOe <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/route_xbar_dp.sv
module route_xbar_dp
  import route_pkg::*;
#(
  parameter int NUM_IN   = 6,
  parameter int NUM_OUT  = 3,
  parameter int SAMPLE_W = 16
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  route_cmd_t                            cmd,
  input  logic [NUM_IN-1:0][SAMPLE_W-1:0]       srcLeft,
  input  logic [NUM_IN-1:0][SAMPLE_W-1:0]       srcRight,
  output logic [NUM_OUT-1:0][SAMPLE_W-1:0]      dstLeft,
  output logic [NUM_OUT-1:0][SAMPLE_W-1:0]      dstRight,
  output logic [NUM_OUT-1:0][SRC_CODE_W-1:0]    selState
);
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic [SRC_CODE_W-1:0] selReg;
    logic [SAMPLE_W-1:0]   pickL, pickR, outL, outR;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        selReg <= SILENCE_CODE;
      end else if (cmd.load && cmd.outIdx == OUT_IDX_W'(o)) begin
        selReg <= cmd.srcCode;
      end
    end

    always_comb begin
      pickL = '0;
      pickR = '0;
      for (int i = 0; i < NUM_IN; i++) begin
        if (selReg == SRC_CODE_W'(i)) begin
          pickL = srcLeft[i];
          pickR = srcRight[i];
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outL <= '0;
        outR <= '0;
      end else begin
        outL <= pickL;
        outR <= pickR;
      end
    end

    assign dstLeft[o]  = outL;
    assign dstRight[o] = outR;
    assign selState[o] = selReg;
  end
endmodule

// File: rtl/stereo_route_matrix.sv
module stereo_route_matrix
  import route_pkg::*;
#(
  parameter int         NUM_IN        = 6,
  parameter int         NUM_OUT       = 3,
  parameter int         SAMPLE_W      = 16,
  parameter logic [6:0] DEV_ADDR_BASE = 7'h4C
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             sclIn,
  input  logic                             sdaIn,
  output logic                             sdaOe,
  input  logic                             addrSel,
  input  logic [NUM_IN-1:0][SAMPLE_W-1:0]  srcLeft,
  input  logic [NUM_IN-1:0][SAMPLE_W-1:0]  srcRight,
  output logic [NUM_OUT-1:0][SAMPLE_W-1:0] dstLeft,
  output logic [NUM_OUT-1:0][SAMPLE_W-1:0] dstRight
);
  route_cmd_t cmd;
  logic [NUM_OUT-1:0][SRC_CODE_W-1:0] selState;

  route_bus_ctrl #(.DEV_ADDR_BASE(DEV_ADDR_BASE)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .addrSel(addrSel),
    .sdaOe  (sdaOe),
    .cmd    (cmd)
  );

  route_xbar_dp #(
    .NUM_IN  (NUM_IN),
    .NUM_OUT (NUM_OUT),
    .SAMPLE_W(SAMPLE_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .srcLeft (srcLeft),
    .srcRight(srcRight),
    .dstLeft (dstLeft),
    .dstRight(dstRight),
    .selState(selState)
  );
endmodule

// File: rtl/route_matrix_chk.sv
module route_matrix_chk
  import route_pkg::*;
#(
  parameter int NUM_IN   = 6,
  parameter int NUM_OUT  = 3,
  parameter int SAMPLE_W = 16
) (
  input logic                               clk,
  input logic                               rstN,
  input logic                               sclIn,
  input logic                               sdaOe,
  input route_cmd_t                         cmd,
  input logic [NUM_OUT-1:0][SRC_CODE_W-1:0] selState,
  input logic [NUM_IN-1:0][SAMPLE_W-1:0]    srcLeft,
  input logic [NUM_IN-1:0][SAMPLE_W-1:0]    srcRight,
  input logic [NUM_OUT-1:0][SAMPLE_W-1:0]   dstLeft,
  input logic [NUM_OUT-1:0][SAMPLE_W-1:0]   dstRight
);
  AST_RESET_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (dstLeft == '0 && dstRight == '0 && !sdaOe)); // R1

  AST_ACK_GRAB_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn); // R11

  AST_ACK_DROP_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaOe) |-> !sclIn); // R11

  AST_RESERVED_DST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.load && cmd.outIdx == 2'b11) |=> $stable(selState)); // R8

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_chk
    logic [SAMPLE_W-1:0] mdlL, mdlR;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mdlL <= '0;
        mdlR <= '0;
      end else begin
        mdlL <= '0;
        mdlR <= '0;
        for (int i = 0; i < NUM_IN; i++) begin
          if (selState[o] == SRC_CODE_W'(i)) begin
            mdlL <= srcLeft[i];
            mdlR <= srcRight[i];
          end
        end
      end
    end

    AST_PAIR_SWITCH: assert property (@(posedge clk) disable iff (!rstN)
      (dstLeft[o] == mdlL && dstRight[o] == mdlR)); // R10

    AST_SILENCE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (selState[o] >= SRC_CODE_W'(NUM_IN)) |=> (dstLeft[o] == '0 && dstRight[o] == '0)); // R7
  end
endmodule

bind stereo_route_matrix route_matrix_chk #(
  .NUM_IN  (NUM_IN),
  .NUM_OUT (NUM_OUT),
  .SAMPLE_W(SAMPLE_W)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .sclIn   (sclIn),
  .sdaOe   (sdaOe),
  .cmd     (cmd),
  .selState(selState),
  .srcLeft (srcLeft),
  .srcRight(srcRight),
  .dstLeft (dstLeft),
  .dstRight(dstRight)
);

// File: tb/stereo_route_matrix_tb_top.sv
module stereo_route_matrix_tb_top;
  localparam int NUM_IN = 6;
  localparam int NUM_OUT = 3;
  localparam int SAMPLE_W = 16;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic sdaLine;
  logic sdaOe;
  logic addrSel = 1'b0;
  logic [NUM_IN-1:0][SAMPLE_W-1:0] srcLeft;
  logic [NUM_IN-1:0][SAMPLE_W-1:0] srcRight;
  logic [NUM_OUT-1:0][SAMPLE_W-1:0] dstLeft;
  logic [NUM_OUT-1:0][SAMPLE_W-1:0] dstRight;

  int testsRun = 0;
  int failCnt = 0;
  bit finished = 0;
  bit monitorOn = 0;
  int pairSkew = 0;

  always #4 clk = ~clk;

  assign sdaLine = sdaDrv & ~sdaOe;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_src
    assign srcLeft[i]  = 16'hA100 + 16'(i);
    assign srcRight[i] = 16'hB200 + 16'(i);
  end

  stereo_route_matrix dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclDrv),
    .sdaIn   (sdaLine),
    .sdaOe   (sdaOe),
    .addrSel (addrSel),
    .srcLeft (srcLeft),
    .srcRight(srcRight),
    .dstLeft (dstLeft),
    .dstRight(dstRight)
  );

  function automatic logic [15:0] expL(input int idx);
    return (idx >= 0 && idx < NUM_IN) ? 16'hA100 + 16'(idx) : 16'h0000;
  endfunction

  function automatic logic [15:0] expR(input int idx);
    return (idx >= 0 && idx < NUM_IN) ? 16'hB200 + 16'(idx) : 16'h0000;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkDst(input string tag, input int o, input int srcIdx);
    check({tag, " left"}, 32'(dstLeft[o]), 32'(expL(srcIdx)));
    check({tag, " right"}, 32'(dstRight[o]), 32'(expR(srcIdx)));
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitClk(Q);
    sclDrv = 1'b1; waitClk(Q);
    sdaDrv = 1'b0; waitClk(Q);
    sclDrv = 1'b0; waitClk(Q);
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitClk(Q);
    sclDrv = 1'b1; waitClk(Q);
    sdaDrv = 1'b1; waitClk(Q);
  endtask

  task automatic busByte(input logic [7:0] b, output logic ackBit);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; waitClk(Q);
      sclDrv = 1'b1; waitClk(2 * Q);
      sclDrv = 1'b0; waitClk(Q);
    end
    sdaDrv = 1'b1; waitClk(Q);
    sclDrv = 1'b1; waitClk(Q);
    ackBit = sdaLine; waitClk(Q);
    sclDrv = 1'b0; waitClk(Q);
  endtask

  task automatic oneCmd(input logic [7:0] addrByte, input logic [7:0] dataByte,
                        output logic aAck, output logic dAck);
    busStart();
    busByte(addrByte, aAck);
    busByte(dataByte, dAck);
    busStop();
    waitClk(8);
  endtask

  task automatic testReset();
    checkDst("R1 dst1 after reset", 0, -1);
    checkDst("R1 dst2 after reset", 1, -1);
    checkDst("R1 dst3 after reset", 2, -1);
    check("R1 sdaOe after reset", 32'(sdaOe), 32'd0);
  endtask

  task automatic testAddrLow();
    logic a, d;
    addrSel = 1'b0; waitClk(4);
    oneCmd(8'h98, 8'h44, a, d);
    check("R2 ack for 0x98", 32'(a), 32'd0);
    check("R5 data ack", 32'(d), 32'd0);
    checkDst("R5 source5 to dst3", 2, 4);
    oneCmd(8'h98, 8'h00, a, d);
    checkDst("R5 source1 to dst1", 0, 0);
    oneCmd(8'h9A, 8'h21, a, d);
    check("R2 no ack for 0x9A", 32'(a), 32'd1);
    checkDst("R2 dst2 untouched", 1, -1);
    check("R11 sda released", 32'(sdaOe), 32'd0);
  endtask

  task automatic testAddrHigh();
    logic a, d;
    addrSel = 1'b1; waitClk(4);
    oneCmd(8'h9A, 8'h23, a, d);
    check("R3 ack for 0x9A", 32'(a), 32'd0);
    checkDst("R3 source4 to dst2", 1, 3);
    oneCmd(8'h98, 8'h05, a, d);
    check("R3 no ack for 0x98", 32'(a), 32'd1);
    checkDst("R3 dst1 untouched", 0, 0);
    addrSel = 1'b0; waitClk(4);
  endtask

  task automatic testReadIgnored();
    logic a, d, d2;
    busStart();
    busByte(8'h99, a);
    busByte(8'h45, d);
    busByte(8'h05, d2);
    busStop();
    waitClk(8);
    check("R4 read address refused", 32'(a), 32'd1);
    check("R4 later byte not acked", 32'(d), 32'd1);
    checkDst("R4 dst3 kept", 2, 4);
    checkDst("R4 dst1 kept", 0, 0);
  endtask

  task automatic testDontCare();
    logic a, d;
    oneCmd(8'h98, 8'hB9, a, d);
    check("R6 ack", 32'(d), 32'd0);
    checkDst("R6 don't-care bits ignored", 1, 1);
  endtask

  task automatic testSilence();
    logic a, d;
    oneCmd(8'h98, 8'h46, a, d);
    checkDst("R7 code 110 silences dst3", 2, -1);
    oneCmd(8'h98, 8'h07, a, d);
    checkDst("R7 code 111 silences dst1", 0, -1);
    check("R7 ack", 32'(d), 32'd0);
  endtask

  task automatic testReservedDst();
    logic a, d;
    oneCmd(8'h98, 8'h62, a, d);
    check("R8 reserved code acked", 32'(d), 32'd0);
    checkDst("R8 dst1 unchanged", 0, -1);
    checkDst("R8 dst2 unchanged", 1, 1);
    checkDst("R8 dst3 unchanged", 2, -1);
  endtask

  task automatic testMultiByte();
    logic a, d0, d1, d2;
    busStart();
    busByte(8'h98, a);
    busByte(8'h05, d0);
    checkDst("R9 first byte applied mid-transaction", 0, 5);
    busByte(8'h24, d1);
    checkDst("R9 second byte applied mid-transaction", 1, 4);
    busByte(8'h40, d2);
    busStop();
    waitClk(8);
    check("R9 all bytes acked", 32'({a, d0, d1, d2}), 32'd0);
    checkDst("R9 third byte applied", 2, 0);
    checkDst("R9 dst1 kept", 0, 5);
  endtask

  always @(negedge clk) begin
    if (monitorOn && ((dstLeft[0] == expL(2)) != (dstRight[0] == expR(2))))
      pairSkew++;
  end

  task automatic testPairSwitch();
    logic a, d;
    monitorOn = 1;
    oneCmd(8'h98, 8'h02, a, d);
    monitorOn = 0;
    check("R10 channels switch on same edge", 32'(pairSkew), 32'd0);
    checkDst("R10 source3 to dst1", 0, 2);
  endtask

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    testReset();
    testAddrLow();
    testAddrHigh();
    testReadIgnored();
    testDontCare();
    testSilence();
    testReservedDst();
    testMultiByte();
    testPairSwitch();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, failCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      failCnt++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, failCnt);
      $finish;
    end
  end
endmodule